// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block owns a small word-addressed register memory and serves it to two requester ports. Each port offers one request at a time through a valid/ready handshake. A request carries an opcode, a word address, an operand, a compare value and a requester identifier. The unit accepts at most one request per clock. When both ports offer a request in the same cycle, a two-way round-robin picks one of them. The read and the write of each atomic operation happen in the same cycle, so no other request can fall between them.

The unit supports plain load and store, fetch-and-add, compare-and-swap, and a linked-load / conditional-store pair. Every response returns the word as it was before the operation, with a success flag. For each requester identifier, the unit keeps one link reservation made of a valid bit and an address. Any successful write to a reserved word breaks every reservation on that word. A counter can therefore be built on any of the atomic primitives and ends in the same state whichever primitive is used.

Top module: `atomic_mem_unit`

## Requirements
- R1: After reset, every memory word reads 0. Neither port shows a response, and a port with no request shows ready low.
- R2: Fetch-and-add (opcode 2) returns the old word with success 1 and writes the old word plus the operand, modulo 2^DATA_W.
- R3: Compare-and-swap (opcode 3) returns the old word. When the old word equals the compare value, it writes the operand and reports success 1. Otherwise memory is unchanged and success is 0.
- R4: Linked load (opcode 4) returns the word with success 1. It sets the requester's reservation to that address and replaces any earlier reservation the requester held.
- R5: Conditional store (opcode 5) writes the operand and reports success 1 only when the requester holds a valid reservation on that same address. Otherwise memory is unchanged and success is 0.
- R6: Every successful write clears the reservations of all requesters on the written address, including the writer's own. This covers store, fetch-and-add, successful compare-and-swap and successful conditional store. Reservations on other addresses are kept.
- R7: When both ports request in the same cycle, the port granted is the one not granted most recently. Port 0 wins first after reset. Exactly one of the two ready outputs is high.
- R8: A request accepted in cycle n produces a response on that port only, in cycle n+1. The response carries the request's identifier, the pre-operation word and the success flag.
- R9: Load (opcode 0) returns the word with success 1. Store (opcode 1) writes the operand and reports success 1. Opcodes 6 and 7 leave memory and reservations unchanged and report success 0.
- R10: Four increments of a word that starts at 0 leave 4 in it. This holds whether the increments are done by fetch-and-add, by compare-and-swap retry, or by linked-load / conditional-store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_valid | input | 1 | Port 0 request valid |
| p0_ready | output | 1 | Port 0 request accepted this cycle |
| p0_op | input | 3 | Port 0 opcode |
| p0_addr | input | ADDR_W | Port 0 word address |
| p0_operand | input | DATA_W | Port 0 store / add / new value |
| p0_cmp | input | DATA_W | Port 0 compare value |
| p0_id | input | ID_W | Port 0 requester identifier |
| p0_rsp_valid | output | 1 | Port 0 response valid |
| p0_rsp_id | output | ID_W | Port 0 response identifier |
| p0_rsp_data | output | DATA_W | Port 0 pre-operation word |
| p0_rsp_ok | output | 1 | Port 0 success flag |
| p1_valid | input | 1 | Port 1 request valid |
| p1_ready | output | 1 | Port 1 request accepted this cycle |
| p1_op | input | 3 | Port 1 opcode |
| p1_addr | input | ADDR_W | Port 1 word address |
| p1_operand | input | DATA_W | Port 1 store / add / new value |
| p1_cmp | input | DATA_W | Port 1 compare value |
| p1_id | input | ID_W | Port 1 requester identifier |
| p1_rsp_valid | output | 1 | Port 1 response valid |
| p1_rsp_id | output | ID_W | Port 1 response identifier |
| p1_rsp_data | output | DATA_W | Port 1 pre-operation word |
| p1_rsp_ok | output | 1 | Port 1 success flag |

## Verification
The assertions assume that request fields stay free of X/Z while valid is high. They also assume that responses need no backpressure, because a response register is overwritten on the next grant. Both assumptions hold because the stimulus drives every field on every cycle and always consumes responses. The random traffic crowds all requests onto four addresses and four identifiers, including the reserved opcodes, so links are broken often and by every kind of writer. Directed sequences cover simultaneous requests, the failure cases and the three counter idioms.

// File: rtl/amu_pkg.sv
package amu_pkg;
   typedef enum logic [2:0] {
      OP_LOAD  = 3'd0,
      OP_STORE = 3'd1,
      OP_FADD  = 3'd2,
      OP_CAS   = 3'd3,
      OP_LINK  = 3'd4,
      OP_COND  = 3'd5,
      OP_RSV6  = 3'd6,
      OP_RSV7  = 3'd7
   } amu_op_e;
endpackage

// File: rtl/amu_rr_arb.sv
module amu_rr_arb (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] req,
   output logic [1:0] gnt
);
   logic favor_q;

   always_comb begin
      gnt = 2'b00;
      if (req == 2'b11) gnt = favor_q ? 2'b10 : 2'b01;
      else              gnt = req;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          favor_q <= 1'b0;
      else if (gnt[0])     favor_q <= 1'b1;
      else if (gnt[1])     favor_q <= 1'b0;
   end

   a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
   a_r7_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req) == 2'b00);
   a_r7_alternate: assert property (@(posedge clk) disable iff (!rst_n)
      (req == 2'b11 && gnt[0]) ##1 (req == 2'b11) |-> gnt[1]);
endmodule

// File: rtl/amu_resv.sv
module amu_resv #(
   parameter int ADDR_W = 4,
   parameter int ID_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_en,
   input  logic [ID_W-1:0]   link_id,
   input  logic [ADDR_W-1:0] link_addr,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [ID_W-1:0]   q_id,
   input  logic [ADDR_W-1:0] q_addr,
   output logic              q_hit
);
   localparam int NREQ = 1 << ID_W;

   logic [NREQ-1:0]   rv_q;
   logic [ADDR_W-1:0] ra_q [NREQ];

   for (genvar r = 0; r < NREQ; r++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rv_q[r] <= 1'b0;
            ra_q[r] <= '0;
         end else if (link_en && link_id == ID_W'(r)) begin
            rv_q[r] <= 1'b1;
            ra_q[r] <= link_addr;
         end else if (wr_en && rv_q[r] && ra_q[r] == wr_addr) begin
            rv_q[r] <= 1'b0;
         end
      end

      a_r6_write_breaks: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && rv_q[r] && ra_q[r] == wr_addr) |=> !rv_q[r]);
      a_r4_link_sets: assert property (@(posedge clk) disable iff (!rst_n)
         (link_en && link_id == ID_W'(r)) |=> (rv_q[r] && ra_q[r] == $past(link_addr)));
   end

   assign q_hit = rv_q[q_id] && (ra_q[q_id] == q_addr);

   a_r6_link_write_exclusive: assert property (@(posedge clk) disable iff (!rst_n) !(link_en && wr_en));
endmodule

// File: rtl/amu_exec.sv
module amu_exec
   import amu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  amu_op_e           op,
   input  logic              fire,
   input  logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] operand,
   input  logic [DATA_W-1:0] cmp,
   input  logic              link_hit,
   output logic              wr_en,
   output logic [DATA_W-1:0] wdata,
   output logic              link_en,
   output logic              ok
);
   always_comb begin
      wr_en   = 1'b0;
      wdata   = operand;
      link_en = 1'b0;
      ok      = 1'b0;
      case (op)
         OP_LOAD:  ok = 1'b1;
         OP_STORE: begin ok = 1'b1; wr_en = 1'b1; end
         OP_FADD:  begin ok = 1'b1; wr_en = 1'b1; wdata = rdata + operand; end
         OP_CAS:   begin ok = (rdata == cmp); wr_en = ok; end
         OP_LINK:  begin ok = 1'b1; link_en = 1'b1; end
         OP_COND:  begin ok = link_hit; wr_en = ok; end
         default:  ok = 1'b0;
      endcase
      wr_en   = wr_en & fire;
      link_en = link_en & fire;
   end
endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit
   import amu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4,
   parameter int ID_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              p0_valid,
   output logic              p0_ready,
   input  logic [2:0]        p0_op,
   input  logic [ADDR_W-1:0] p0_addr,
   input  logic [DATA_W-1:0] p0_operand,
   input  logic [DATA_W-1:0] p0_cmp,
   input  logic [ID_W-1:0]   p0_id,
   output logic              p0_rsp_valid,
   output logic [ID_W-1:0]   p0_rsp_id,
   output logic [DATA_W-1:0] p0_rsp_data,
   output logic              p0_rsp_ok,
   input  logic              p1_valid,
   output logic              p1_ready,
   input  logic [2:0]        p1_op,
   input  logic [ADDR_W-1:0] p1_addr,
   input  logic [DATA_W-1:0] p1_operand,
   input  logic [DATA_W-1:0] p1_cmp,
   input  logic [ID_W-1:0]   p1_id,
   output logic              p1_rsp_valid,
   output logic [ID_W-1:0]   p1_rsp_id,
   output logic [DATA_W-1:0] p1_rsp_data,
   output logic              p1_rsp_ok
);
   localparam int DEPTH = 1 << ADDR_W;

   if (DATA_W < 2 || DATA_W > 64) begin : g_bad_data
      $error("atomic_mem_unit: DATA_W out of range");
   end
   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr
      $error("atomic_mem_unit: ADDR_W out of range");
   end
   if (ID_W < 1 || ID_W > 4) begin : g_bad_id
      $error("atomic_mem_unit: ID_W out of range");
   end

   logic [1:0]        gnt;
   logic              fire;
   amu_op_e           s_op;
   logic [ADDR_W-1:0] s_addr;
   logic [DATA_W-1:0] s_operand, s_cmp, rdata, wdata;
   logic [ID_W-1:0]   s_id;
   logic              wr_en, link_en, link_hit, ok;
   logic [DATA_W-1:0] mem_q [DEPTH];

   logic [1:0]        rsp_v_q;
   logic [ID_W-1:0]   rsp_id_q;
   logic [DATA_W-1:0] rsp_data_q;
   logic              rsp_ok_q;

   amu_rr_arb u_arb (
      .clk (clk), .rst_n (rst_n), .req ({p1_valid, p0_valid}), .gnt (gnt)
   );

   assign p0_ready = gnt[0];
   assign p1_ready = gnt[1];
   assign fire     = |gnt;

   always_comb begin
      if (gnt[1]) begin
         s_op = amu_op_e'(p1_op); s_addr = p1_addr; s_operand = p1_operand;
         s_cmp = p1_cmp; s_id = p1_id;
      end else begin
         s_op = amu_op_e'(p0_op); s_addr = p0_addr; s_operand = p0_operand;
         s_cmp = p0_cmp; s_id = p0_id;
      end
   end

   assign rdata = mem_q[s_addr];

   amu_resv #(.ADDR_W (ADDR_W), .ID_W (ID_W)) u_resv (
      .clk (clk), .rst_n (rst_n),
      .link_en (link_en), .link_id (s_id), .link_addr (s_addr),
      .wr_en (wr_en), .wr_addr (s_addr),
      .q_id (s_id), .q_addr (s_addr), .q_hit (link_hit)
   );

   amu_exec #(.DATA_W (DATA_W)) u_exec (
      .op (s_op), .fire (fire), .rdata (rdata), .operand (s_operand), .cmp (s_cmp),
      .link_hit (link_hit), .wr_en (wr_en), .wdata (wdata), .link_en (link_en), .ok (ok)
   );

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)                                mem_q[w] <= '0;
         else if (wr_en && s_addr == ADDR_W'(w))    mem_q[w] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_v_q    <= 2'b00;
         rsp_id_q   <= '0;
         rsp_data_q <= '0;
         rsp_ok_q   <= 1'b0;
      end else begin
         rsp_v_q <= gnt;
         if (fire) begin
            rsp_id_q   <= s_id;
            rsp_data_q <= rdata;
            rsp_ok_q   <= ok;
         end
      end
   end

   assign p0_rsp_valid = rsp_v_q[0];
   assign p1_rsp_valid = rsp_v_q[1];
   assign p0_rsp_id    = rsp_id_q;
   assign p1_rsp_id    = rsp_id_q;
   assign p0_rsp_data  = rsp_data_q;
   assign p1_rsp_data  = rsp_data_q;
   assign p0_rsp_ok    = rsp_ok_q;
   assign p1_rsp_ok    = rsp_ok_q;

   a_r2_fadd_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && s_op == OP_FADD) |=> mem_q[$past(s_addr)] == $past(rdata) + $past(s_operand));
   a_r3_cas_miss_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && s_op == OP_CAS && rdata != s_cmp) |=> mem_q[$past(s_addr)] == $past(rdata));
   a_r5_cond_fail_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && s_op == OP_COND && !link_hit) |=> (mem_q[$past(s_addr)] == $past(rdata) && !p0_rsp_ok));
   a_r8_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (p0_rsp_valid == $past(gnt[0]) && p1_rsp_valid == $past(gnt[1]) && p0_rsp_data == $past(rdata)));
   a_r9_reserved_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (s_op == OP_RSV6 || s_op == OP_RSV7)) |=> mem_q[$past(s_addr)] == $past(rdata));
endmodule

// File: tb/sim_atomic_mem_unit.sv
module sim_atomic_mem_unit;
   localparam int DW = 32, AW = 4, IW = 2, NW = 16, NR = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          v0 = 0, v1 = 0;
   logic [2:0]    op0 = 0, op1 = 0;
   logic [AW-1:0] a0 = 0, a1 = 0;
   logic [DW-1:0] d0 = 0, d1 = 0, e0 = 0, e1 = 0;
   logic [IW-1:0] i0 = 0, i1 = 0;
   logic          r0, r1, rv0, rv1, ok0, ok1;
   logic [IW-1:0] ri0, ri1;
   logic [DW-1:0] rd0, rd1;

   atomic_mem_unit #(.DATA_W (DW), .ADDR_W (AW), .ID_W (IW)) u0 (
      .clk (clk), .rst_n (rst_n),
      .p0_valid (v0), .p0_ready (r0), .p0_op (op0), .p0_addr (a0), .p0_operand (d0),
      .p0_cmp (e0), .p0_id (i0), .p0_rsp_valid (rv0), .p0_rsp_id (ri0),
      .p0_rsp_data (rd0), .p0_rsp_ok (ok0),
      .p1_valid (v1), .p1_ready (r1), .p1_op (op1), .p1_addr (a1), .p1_operand (d1),
      .p1_cmp (e1), .p1_id (i1), .p1_rsp_valid (rv1), .p1_rsp_id (ri1),
      .p1_rsp_data (rd1), .p1_rsp_ok (ok1)
   );

   int checks = 0, failures = 0;
   logic [DW-1:0] mm [NW];
   logic          mrv [NR];
   logic [AW-1:0] mra [NR];
   logic          mfav = 0;
   logic [DW-1:0] last_data;
   logic          last_ok;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [DW:0] model(input logic [2:0] op, input logic [AW-1:0] a,
                                         input logic [DW-1:0] d, input logic [DW-1:0] e,
                                         input logic [IW-1:0] id);
      logic [DW-1:0] old;
      logic ok, w;
      old = mm[a]; ok = 0; w = 0;
      case (op)
         3'd0: ok = 1;
         3'd1: begin ok = 1; w = 1; end
         3'd2: begin ok = 1; w = 1; d = old + d; end
         3'd3: begin ok = (old == e); w = ok; end
         3'd4: begin ok = 1; mrv[id] = 1; mra[id] = a; end
         3'd5: begin ok = mrv[id] && mra[id] == a; w = ok; end
         default: ok = 0;
      endcase
      if (w) begin
         mm[a] = d;
         for (int r = 0; r < NR; r++) if (mrv[r] && mra[r] == a) mrv[r] = 0;
      end
      return {ok, old};
   endfunction

   // drive one cycle on both ports; checks grant and the following response
   task automatic step(input string tag,
                       input logic x0, input logic [2:0] o0, input logic [AW-1:0] aa0,
                       input logic [DW-1:0] dd0, input logic [DW-1:0] ee0, input logic [IW-1:0] ii0,
                       input logic x1, input logic [2:0] o1, input logic [AW-1:0] aa1,
                       input logic [DW-1:0] dd1, input logic [DW-1:0] ee1, input logic [IW-1:0] ii1);
      logic g0, g1;
      logic [DW:0] res;
      logic [IW-1:0] gid;
      v0 = x0; op0 = o0; a0 = aa0; d0 = dd0; e0 = ee0; i0 = ii0;
      v1 = x1; op1 = o1; a1 = aa1; d1 = dd1; e1 = ee1; i1 = ii1;
      #1;
      g0 = x0 && (!x1 || !mfav);
      g1 = x1 && !g0;
      chk({tag, " R7 ready0"}, {63'd0, r0}, {63'd0, g0});
      chk({tag, " R7 ready1"}, {63'd0, r1}, {63'd0, g1});
      res = '0; gid = '0;
      if (g0) begin res = model(o0, aa0, dd0, ee0, ii0); gid = ii0; mfav = 1; end
      if (g1) begin res = model(o1, aa1, dd1, ee1, ii1); gid = ii1; mfav = 0; end
      @(negedge clk);
      v0 = 0; v1 = 0;
      chk({tag, " R8 rsp_valid0"}, {63'd0, rv0}, {63'd0, g0});
      chk({tag, " R8 rsp_valid1"}, {63'd0, rv1}, {63'd0, g1});
      if (g0) begin
         chk({tag, " R8 id0"}, {62'd0, ri0}, {62'd0, gid});
         chk({tag, " data0"}, {32'd0, rd0}, {32'd0, res[DW-1:0]});
         chk({tag, " ok0"}, {63'd0, ok0}, {63'd0, res[DW]});
         last_data = rd0; last_ok = ok0;
      end
      if (g1) begin
         chk({tag, " R8 id1"}, {62'd0, ri1}, {62'd0, gid});
         chk({tag, " data1"}, {32'd0, rd1}, {32'd0, res[DW-1:0]});
         chk({tag, " ok1"}, {63'd0, ok1}, {63'd0, res[DW]});
         last_data = rd1; last_ok = ok1;
      end
   endtask

   task automatic op_p0(input string tag, input logic [2:0] o, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [DW-1:0] e, input logic [IW-1:0] id);
      step(tag, 1, o, a, d, e, id, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic op_p1(input string tag, input logic [2:0] o, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [DW-1:0] e, input logic [IW-1:0] id);
      step(tag, 0, 0, 0, 0, 0, 0, 1, o, a, d, e, id);
   endtask

   initial begin
      #200000;
      failures++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
   end

   initial begin
      logic [DW-1:0] seen;
      void'($urandom(32'd1234));
      for (int w = 0; w < NW; w++) mm[w] = 0;
      for (int r = 0; r < NR; r++) begin mrv[r] = 0; mra[r] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      chk("R1 idle ready0", {63'd0, r0}, 64'd0);
      chk("R1 idle ready1", {63'd0, r1}, 64'd0);
      chk("R1 no rsp0", {63'd0, rv0}, 64'd0);
      chk("R1 no rsp1", {63'd0, rv1}, 64'd0);
      @(negedge clk);
      for (int w = 0; w < NW; w++) op_p0("R1 zero word", 3'd0, AW'(w), 0, 0, 0);

      // R9 plain store/load, reserved opcodes
      op_p0("R9 store", 3'd1, 4'd7, 32'hCAFE_0001, 0, 1);
      op_p1("R9 load", 3'd0, 4'd7, 0, 0, 2);
      op_p0("R9 op6", 3'd6, 4'd7, 32'h1, 0, 0);
      op_p1("R9 op7", 3'd7, 4'd7, 32'h2, 0, 3);
      op_p0("R9 load after reserved", 3'd0, 4'd7, 0, 0, 0);

      // R2 fetch-and-add with wrap
      op_p0("R2 store max", 3'd1, 4'd8, 32'hFFFF_FFFE, 0, 0);
      op_p1("R2 fadd wrap", 3'd2, 4'd8, 32'd5, 0, 1);
      op_p0("R2 readback", 3'd0, 4'd8, 0, 0, 0);

      // R3 compare-and-swap hit and miss
      op_p0("R3 cas hit", 3'd3, 4'd9, 32'h55, 32'h0, 0);
      op_p0("R3 cas miss", 3'd3, 4'd9, 32'h66, 32'h0, 0);
      op_p1("R3 readback", 3'd0, 4'd9, 0, 0, 2);

      // R4/R5 link then conditional store, replaced link
      op_p0("R4 link", 3'd4, 4'd10, 0, 0, 1);
      op_p0("R5 cond ok", 3'd5, 4'd10, 32'h77, 0, 1);
      op_p0("R5 cond again fails", 3'd5, 4'd10, 32'h88, 0, 1);
      op_p0("R4 link a", 3'd4, 4'd11, 0, 0, 2);
      op_p0("R4 link b replaces", 3'd4, 4'd12, 0, 0, 2);
      op_p0("R4 cond old addr fails", 3'd5, 4'd11, 32'h9, 0, 2);
      op_p0("R5 cond unlinked id fails", 3'd5, 4'd12, 32'h9, 0, 3);
      op_p0("R5 cond new addr ok", 3'd5, 4'd12, 32'h9, 0, 2);

      // R6 other requester's writes break links
      op_p0("R6 link", 3'd4, 4'd13, 0, 0, 0);
      op_p1("R6 link", 3'd4, 4'd14, 0, 0, 1);
      op_p1("R6 store breaks", 3'd1, 4'd13, 32'h3, 0, 3);
      op_p0("R6 cond broken", 3'd5, 4'd13, 32'h4, 0, 0);
      op_p1("R6 other addr kept", 3'd5, 4'd14, 32'h4, 0, 1);
      op_p0("R6 link", 3'd4, 4'd13, 0, 0, 0);
      op_p1("R6 fadd breaks", 3'd2, 4'd13, 32'h1, 0, 2);
      op_p0("R6 cond broken by fadd", 3'd5, 4'd13, 32'h4, 0, 0);
      op_p0("R6 link", 3'd4, 4'd13, 0, 0, 0);
      op_p1("R6 cas miss keeps", 3'd3, 4'd13, 32'h1, 32'hDEAD, 2);
      op_p0("R6 cond survives miss", 3'd5, 4'd13, 32'h4, 0, 0);

      // R7 simultaneous requests alternate
      step("R7 both a", 1, 3'd0, 4'd1, 0, 0, 0, 1, 3'd0, 4'd2, 0, 0, 1);
      step("R7 both b", 1, 3'd0, 4'd1, 0, 0, 0, 1, 3'd0, 4'd2, 0, 0, 1);
      step("R7 both c", 1, 3'd2, 4'd1, 1, 0, 0, 1, 3'd2, 4'd1, 1, 0, 1);
      step("R7 both d", 1, 3'd2, 4'd1, 1, 0, 0, 1, 3'd2, 4'd1, 1, 0, 1);

      // R10 counters by three idioms
      for (int k = 0; k < 4; k++) op_p0("R10 fadd inc", 3'd2, 4'd3, 1, 0, 0);
      op_p1("R10 fadd total", 3'd0, 4'd3, 0, 0, 0);
      chk("R10 fadd count", {32'd0, last_data}, 64'd4);
      for (int k = 0; k < 4; k++) begin
         op_p1("R10 cas read", 3'd0, 4'd4, 0, 0, 1);
         seen = last_data;
         step("R10 cas contend", 1, 3'd1, 4'd5, 0, 0, 0, 0, 0, 0, 0, 0, 0);
         op_p1("R10 cas inc", 3'd3, 4'd4, seen + 1, seen, 1);
      end
      op_p0("R10 cas total", 3'd0, 4'd4, 0, 0, 0);
      chk("R10 cas count", {32'd0, last_data}, 64'd4);
      for (int k = 0; k < 4; k++) begin
         op_p0("R10 link read", 3'd4, 4'd6, 0, 0, 3);
         seen = last_data;
         op_p0("R10 cond inc", 3'd5, 4'd6, seen + 1, 0, 3);
      end
      op_p1("R10 link total", 3'd0, 4'd6, 0, 0, 0);
      chk("R10 link count", {32'd0, last_data}, 64'd4);

      // random traffic on a few hot addresses
      for (int n = 0; n < 3000; n++) begin
         step("R2 R3 R5 R6 R9 random",
              ($urandom % 10) < 7, 3'($urandom % 8), AW'($urandom % 4), DW'($urandom % 8),
              DW'($urandom % 8), IW'($urandom % 4),
              ($urandom % 10) < 7, 3'($urandom % 8), AW'($urandom % 4), DW'($urandom % 8),
              DW'($urandom % 8), IW'($urandom % 4));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule